// File: doc/BRIEF.md
# ADC Step Sequencer

This block walks a table of sixteen conversion steps and sends one conversion request to an ADC for each step that is currently enabled. Each step has a 32-bit configuration word. The word picks the analog input, chooses whether the step fires once or on every pass, and names which of two result queues gets the sample. The ADC is modelled as a start pulse followed by a done pulse that carries a 12-bit sample.

Software programs the block through a flat register port. The port holds the sixteen configuration words, a 16-bit step-enable mask, a control word with a run bit, and one status word for each queue. A step in one-shot mode removes itself from the mask once its sample has been taken, so it stays dormant until software re-arms it. A step in continuous mode converts again on every pass and needs no software action. Consumers drain the two queues through separate pop ports. Each queue entry carries the sample and the number of the step that produced it.

Top module: `adc_step_sequencer`

## Requirements
- R1: Within a pass, enabled steps are visited in rising step number. After the highest enabled step, the scan wraps to the lowest enabled step.
- R2: Config bits 1:0 equal to 00 select one-shot mode. After its conversion completes, that step's mask bit is cleared and later passes skip it.
- R3: Any nonzero value in config bits 1:0 selects continuous mode. The step's mask bit stays set and the step converts again on every pass.
- R4: Config bits 22:19 drive `adc_chan` during the single-cycle `adc_start` pulse. For example, the word 0x00280000 requests input 5.
- R5: Config bit 26 routes the result. A value of 0 routes it to queue 0 and a value of 1 routes it to queue 1. An entry holds the step number in bits 15:12 and the sample in bits 11:0.
- R6: Control register bit 0 is the run bit. While it is 0, no request is issued. Clearing it halts the scan and discards any conversion still in flight.
- R7: While the mask is all zero, the block idles and issues no request.
- R8: Each queue holds up to 64 entries and reports a live count and an empty flag.
- R9: A result aimed at a full queue is dropped and the queue contents are kept. That queue's sticky overflow flag is set. Writing 1 to status bit 17 clears it.
- R10: Popping an empty queue returns zero and leaves the count at zero.
- R11: A mask write made while a conversion is in progress is used for the next step selection.
- R12: Register map: 0x00–0x0F hold the config words of steps 0–15; 0x10 is the mask; 0x11 is control; 0x12 and 0x13 are queue 0 and queue 1 status (count in bits 15:0, empty in bit 16, overflow in bit 17). All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| adc_start | output | 1 | One-cycle conversion request |
| adc_chan | output | 4 | Analog input for the current request |
| adc_done | input | 1 | Conversion complete pulse |
| adc_sample | input | 12 | Sample that is valid with `adc_done` |
| f0_pop | input | 1 | Pop queue 0 |
| f0_data | output | 16 | Head of queue 0, or zero when empty |
| f0_count | output | 7 | Entries in queue 0 |
| f0_empty | output | 1 | Queue 0 empty |
| f0_ovf | output | 1 | Queue 0 sticky overflow |
| f1_pop | input | 1 | Pop queue 1 |
| f1_data | output | 16 | Head of queue 1, or zero when empty |
| f1_count | output | 7 | Entries in queue 1 |
| f1_empty | output | 1 | Queue 1 empty |
| f1_ovf | output | 1 | Queue 1 sticky overflow |

## Verification
The assertions assume that the ADC raises `adc_done` only after a request and pulses it once per request. They also assume that software writes the mask and the config words through the register port, never mid-cycle. The bench's converter model answers each start pulse with exactly one done pulse three cycles later. It drives every input at the falling edge. Each scenario toggles the run bit off before reconfiguring, so a done pulse that arrives after a stop is the only out-of-order event the block ever sees. That event is one the design is required to ignore.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    localparam int STEPS      = 16;
    localparam int STEP_W     = $clog2(STEPS);
    localparam int SAMPLE_W   = 12;
    localparam int CHAN_W     = 4;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 6;
    localparam int FIFO_DEPTH = 64;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int ENTRY_W    = STEP_W + SAMPLE_W;

    // field positions inside a step word
    localparam int ROUTE_BIT  = 26;
    localparam int CHAN_LO    = 19;
    localparam int OVF_BIT    = 17;
    localparam int EMPTY_BIT  = 16;

    localparam logic [ADDR_W-1:0] A_MASK  = 6'h10;
    localparam logic [ADDR_W-1:0] A_CTRL  = 6'h11;
    localparam logic [ADDR_W-1:0] A_STAT0 = 6'h12;
    localparam logic [ADDR_W-1:0] A_STAT1 = 6'h13;

    typedef struct packed {
        logic [STEP_W-1:0]   step;
        logic [SAMPLE_W-1:0] sample;
    } entry_t;

    typedef enum logic {SQ_IDLE, SQ_WAIT} sq_state_t;

    // first enabled step at or after 'from', wrapping around
    function automatic logic [STEP_W-1:0] pick_step(input logic [STEPS-1:0] mask,
                                                    input logic [STEP_W-1:0] from);
        logic [STEP_W-1:0] idx;
        logic [STEP_W-1:0] res;
        logic hit;
        res = from;
        hit = 1'b0;
        for (int i = 0; i < STEPS; i++) begin
            idx = from + STEP_W'(i);
            if (mask[idx] && !hit) begin
                res = idx;
                hit = 1'b1;
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/adcseq_fifo.sv
module adcseq_fifo #(
    parameter int DEPTH = adcseq_pkg::FIFO_DEPTH,
    parameter int WIDTH = adcseq_pkg::ENTRY_W,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    input  logic             ovf_clr,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             ovf
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
            if (push && full) ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    assert_full_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == CW'(DEPTH)) && ovf);
    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
    import adcseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [STEPS-1:0]    mask,
    output logic                run,
    output logic [CHAN_W-1:0]   chan    [STEPS],
    output logic [STEPS-1:0]    route,
    output logic [STEPS-1:0]    oneshot,
    input  logic                clr_req,
    input  logic [STEP_W-1:0]   clr_idx,
    input  logic [CNT_W-1:0]    cnt0,
    input  logic [CNT_W-1:0]    cnt1,
    input  logic [1:0]          empty,
    input  logic [1:0]          ovf,
    output logic [1:0]          ovf_clr
);
    logic [DATA_W-1:0] cfg [STEPS];
    logic mask_wr;

    assign mask_wr = we && (addr == A_MASK);
    assign ovf_clr[0] = we && (addr == A_STAT0) && wdata[OVF_BIT];
    assign ovf_clr[1] = we && (addr == A_STAT1) && wdata[OVF_BIT];

    for (genvar s = 0; s < STEPS; s++) begin : g_step
        always_ff @(posedge clk) begin
            if (rst) cfg[s] <= '0;
            else if (we && addr == ADDR_W'(s)) cfg[s] <= wdata;
        end
        assign chan[s]    = cfg[s][CHAN_LO +: CHAN_W];
        assign route[s]   = cfg[s][ROUTE_BIT];
        assign oneshot[s] = (cfg[s][1:0] == 2'b00);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            run  <= 1'b0;
        end else begin
            if (mask_wr) mask <= wdata[STEPS-1:0];
            else if (clr_req) mask[clr_idx] <= 1'b0;
            if (we && addr == A_CTRL) run <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr < ADDR_W'(STEPS)) rdata = cfg[addr[STEP_W-1:0]];
        else begin
            case (addr)
                A_MASK:  rdata[STEPS-1:0] = mask;
                A_CTRL:  rdata[0] = run;
                A_STAT0: begin
                    rdata[CNT_W-1:0] = cnt0;
                    rdata[EMPTY_BIT] = empty[0];
                    rdata[OVF_BIT]   = ovf[0];
                end
                A_STAT1: begin
                    rdata[CNT_W-1:0] = cnt1;
                    rdata[EMPTY_BIT] = empty[1];
                    rdata[OVF_BIT]   = ovf[1];
                end
                default: rdata = '0;
            endcase
        end
    end

    assert_oneshot_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !mask_wr) |=> !mask[$past(clr_idx)]);
endmodule

// File: rtl/adcseq_scan.sv
module adcseq_scan
    import adcseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [STEPS-1:0]    mask,
    input  logic [CHAN_W-1:0]   chan    [STEPS],
    input  logic [STEPS-1:0]    route,
    input  logic [STEPS-1:0]    oneshot,
    output logic                adc_start,
    output logic [CHAN_W-1:0]   adc_chan,
    input  logic                adc_done,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic [1:0]          push,
    output entry_t              push_data,
    output logic                clr_req,
    output logic [STEP_W-1:0]   clr_idx
);
    sq_state_t         state;
    logic [STEP_W-1:0] cur, step_q, sel;
    logic              route_q, once_q, finish;

    assign sel    = pick_step(mask, cur);
    assign finish = run && (state == SQ_WAIT) && adc_done;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state     <= SQ_IDLE;
            cur       <= '0;
            step_q    <= '0;
            adc_chan  <= '0;
            route_q   <= 1'b0;
            once_q    <= 1'b0;
            adc_start <= 1'b0;
        end else begin
            adc_start <= 1'b0;
            case (state)
                SQ_IDLE: if (|mask) begin
                    step_q    <= sel;
                    adc_chan  <= chan[sel];
                    route_q   <= route[sel];
                    once_q    <= oneshot[sel];
                    adc_start <= 1'b1;
                    state     <= SQ_WAIT;
                end
                SQ_WAIT: if (adc_done) begin
                    cur   <= step_q + 1'b1;
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign push[0]          = finish && !route_q;
    assign push[1]          = finish && route_q;
    assign push_data.step   = step_q;
    assign push_data.sample = adc_sample;
    assign clr_req          = finish && once_q;
    assign clr_idx          = step_q;

    assert_halt_no_start_R6: assert property (@(posedge clk) disable iff (rst)
        !run |=> !adc_start);
    assert_pick_enabled_R1: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> ((($past(mask) >> step_q) & 16'h1) != 16'h0));
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE && mask == '0) |=> !adc_start);
endmodule

// File: rtl/adc_step_sequencer.sv
module adc_step_sequencer
    import adcseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                adc_start,
    output logic [CHAN_W-1:0]   adc_chan,
    input  logic                adc_done,
    input  logic [SAMPLE_W-1:0] adc_sample,
    input  logic                f0_pop,
    output logic [ENTRY_W-1:0]  f0_data,
    output logic [CNT_W-1:0]    f0_count,
    output logic                f0_empty,
    output logic                f0_ovf,
    input  logic                f1_pop,
    output logic [ENTRY_W-1:0]  f1_data,
    output logic [CNT_W-1:0]    f1_count,
    output logic                f1_empty,
    output logic                f1_ovf
);
    logic [STEPS-1:0]   mask, route, oneshot;
    logic [CHAN_W-1:0]  chan [STEPS];
    logic               run, clr_req;
    logic [STEP_W-1:0]  clr_idx;
    logic [1:0]         push, pop, empty, ovf, ovf_clr;
    entry_t             push_data;
    logic [ENTRY_W-1:0] dout [2];
    logic [CNT_W-1:0]   cnt  [2];

    assign pop = {f1_pop, f0_pop};

    adcseq_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .mask(mask), .run(run), .chan(chan), .route(route),
        .oneshot(oneshot), .clr_req(clr_req), .clr_idx(clr_idx),
        .cnt0(cnt[0]), .cnt1(cnt[1]), .empty(empty), .ovf(ovf), .ovf_clr(ovf_clr)
    );

    adcseq_scan u_scan (
        .clk(clk), .rst(rst), .run(run), .mask(mask), .chan(chan), .route(route),
        .oneshot(oneshot), .adc_start(adc_start), .adc_chan(adc_chan),
        .adc_done(adc_done), .adc_sample(adc_sample), .push(push),
        .push_data(push_data), .clr_req(clr_req), .clr_idx(clr_idx)
    );

    for (genvar q = 0; q < 2; q++) begin : g_q
        adcseq_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
            .clk(clk), .rst(rst), .push(push[q]), .wdata(push_data),
            .pop(pop[q]), .ovf_clr(ovf_clr[q]), .rdata(dout[q]),
            .count(cnt[q]), .empty(empty[q]), .ovf(ovf[q])
        );
    end

    assign f0_data  = dout[0];
    assign f1_data  = dout[1];
    assign f0_count = cnt[0];
    assign f1_count = cnt[1];
    assign f0_empty = empty[0];
    assign f1_empty = empty[1];
    assign f0_ovf   = ovf[0];
    assign f1_ovf   = ovf[1];

    assert_route_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(push));
endmodule

// File: tb/tb_adc_step_sequencer.sv
`timescale 1ns/1ps
module tb_adc_step_sequencer;
    import adcseq_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic adc_start, adc_done = 1'b0;
    logic [3:0] adc_chan;
    logic [11:0] adc_sample = '0;
    logic f0_pop = 1'b0, f1_pop = 1'b0;
    logic [15:0] f0_data, f1_data;
    logic [6:0] f0_count, f1_count;
    logic f0_empty, f0_ovf, f1_empty, f1_ovf;

    adc_step_sequencer dut (.*);

    int n_chk = 0, n_fail = 0, log_n = 0;
    logic [3:0] log_ch [512];
    logic [11:0] log_smp [512];
    logic [7:0] seq = '0;

    // converter model: three cycles from request to done
    initial begin
        forever begin
            @(negedge clk);
            if (adc_start) begin
                log_ch[log_n] = adc_chan;
                log_smp[log_n] = {adc_chan, seq};
                adc_sample = {adc_chan, seq};
                seq = seq + 1;
                log_n = log_n + 1;
                repeat (3) @(negedge clk);
                adc_done = 1'b1;
                @(negedge clk);
                adc_done = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int ch, input int rt, input int md);
        return (32'(rt) << 26) | (32'(ch) << 19) | 32'(md);
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic pop(input int q, output logic [15:0] d);
        if (q == 0) f0_pop = 1'b1; else f1_pop = 1'b1;
        #1 d = (q == 0) ? f0_data : f1_data;
        @(negedge clk);
        f0_pop = 1'b0; f1_pop = 1'b0;
    endtask

    task automatic drain();
        logic [15:0] d;
        while (!f0_empty) pop(0, d);
        while (!f1_empty) pop(1, d);
    endtask

    task automatic wait_starts(input int n);
        int t = 0;
        while (log_n < n && t < 5000) begin @(negedge clk); t++; end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_MASK, d);  chk("R12 mask reset", d, 0);
        rd(A_CTRL, d);  chk("R12 ctrl reset", d, 0);
        rd(A_STAT0, d); chk("R12 stat0 reset", d, 32'h0001_0000);
        chk("R8 empty at reset", {31'b0, f0_empty}, 1);
        chk("R8 count at reset", {25'b0, f0_count}, 0);
    endtask

    task automatic t_idle();
        int base = log_n;
        wr(A_CTRL, 1);
        repeat (40) @(negedge clk);
        chk("R7 no request with empty mask", 32'(log_n), 32'(base));
        wr(A_CTRL, 0);
        wr(6'h00, mk(0, 0, 1));
        wr(A_MASK, 1);
        repeat (40) @(negedge clk);
        chk("R6 no request while halted", 32'(log_n), 32'(base));
        wr(A_MASK, 0);
    endtask

    task automatic t_continuous();
        int base = log_n;
        int exp_s[6] = '{2, 5, 9, 2, 5, 9};
        logic [15:0] d;
        logic [31:0] r;
        wr(6'h02, mk(2, 0, 1));
        wr(6'h05, mk(5, 0, 2));
        wr(6'h09, mk(9, 0, 3));
        wr(A_MASK, 32'h0224);
        wr(A_CTRL, 1);
        wait_starts(base + 6);
        wr(A_CTRL, 0);
        repeat (10) @(negedge clk);
        for (int k = 0; k < 6; k++) chk("R1 R3 scan order", 32'(log_ch[base+k]), 32'(exp_s[k]));
        chk("R6 halted conversion discarded", 32'(f0_count), 5);
        chk("R5 queue 1 untouched", {31'b0, f1_empty}, 1);
        for (int k = 0; k < 5; k++) begin
            pop(0, d);
            chk("R5 entry layout", 32'(d), {16'b0, 4'(exp_s[k]), log_smp[base+k]});
        end
        rd(A_MASK, r); chk("R3 continuous bits kept", r, 32'h0224);
        wr(A_MASK, 0);
    endtask

    task automatic t_oneshot();
        int base = log_n;
        int exp_s[4] = '{1, 3, 3, 3};
        logic [15:0] d;
        logic [31:0] r;
        wr(6'h01, mk(1, 1, 0));
        wr(6'h03, mk(3, 0, 1));
        wr(A_MASK, 32'h000A);
        wr(A_CTRL, 1);
        wait_starts(base + 4);
        wr(A_CTRL, 0);
        repeat (10) @(negedge clk);
        for (int k = 0; k < 4; k++) chk("R2 one-shot skipped later", 32'(log_ch[base+k]), 32'(exp_s[k]));
        rd(A_MASK, r); chk("R2 one-shot bit cleared", r, 32'h0008);
        chk("R5 queue 1 count", 32'(f1_count), 1);
        pop(1, d);
        chk("R5 routed to queue 1", 32'(d), {16'b0, 4'd1, log_smp[base]});
        chk("R5 queue 0 count", 32'(f0_count), 2);
        drain();
        wr(A_MASK, 0);
    endtask

    task automatic t_channel();
        int base = log_n;
        logic [15:0] d;
        logic [31:0] r;
        wr(6'h00, 32'h0028_0000);
        wr(A_MASK, 1);
        wr(A_CTRL, 1);
        wait_starts(base + 1);
        repeat (20) @(negedge clk);
        chk("R4 channel field", 32'(log_ch[base]), 5);
        chk("R2 single conversion", 32'(log_n), 32'(base + 1));
        rd(A_MASK, r); chk("R2 mask cleared", r, 0);
        pop(0, d);
        chk("R4 sample from input 5", 32'(d), {16'b0, 4'd0, log_smp[base]});
        wr(A_CTRL, 0);
        drain();
    endtask

    task automatic t_midpass();
        int base = log_n;
        int exp_s[3] = '{0, 4, 8};
        wr(6'h00, mk(0, 0, 1));
        wr(6'h04, mk(4, 0, 1));
        wr(6'h08, mk(8, 0, 1));
        wr(A_MASK, 32'h0101);
        wr(A_CTRL, 1);
        wait_starts(base + 1);
        wr(A_MASK, 32'h0111);
        wait_starts(base + 3);
        wr(A_CTRL, 0);
        repeat (10) @(negedge clk);
        for (int k = 0; k < 3; k++) chk("R11 mid-pass mask write", 32'(log_ch[base+k]), 32'(exp_s[k]));
        drain();
        wr(A_MASK, 0);
    endtask

    task automatic t_overflow();
        int base = log_n;
        logic [15:0] d;
        logic [31:0] r;
        wr(6'h00, mk(0, 0, 1));
        wr(A_MASK, 1);
        wr(A_CTRL, 1);
        wait_starts(base + 67);
        wr(A_CTRL, 0);
        repeat (10) @(negedge clk);
        chk("R8 full count", 32'(f0_count), 64);
        chk("R9 overflow flag", {31'b0, f0_ovf}, 1);
        rd(A_STAT0, r); chk("R12 status word", r, 32'h0002_0040);
        pop(0, d);
        chk("R9 oldest entry kept", 32'(d), {16'b0, 4'd0, log_smp[base]});
        wr(A_STAT0, 32'h0002_0000);
        chk("R9 overflow cleared", {31'b0, f0_ovf}, 0);
        while (!f0_empty) pop(0, d);
        pop(0, d);
        chk("R10 empty pop data", 32'(d), 0);
        chk("R10 empty pop count", 32'(f0_count), 0);
        wr(A_MASK, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all) actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_continuous();
        t_oneshot();
        t_channel();
        t_midpass();
        t_overflow();
        finish_run();
    end
endmodule